// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock Core with Two Alarms

This block is the register-mapped core of a real-time clock. A 32-bit unsigned seconds count advances by one whenever the one-second tick input is high in a clock cycle. Two alarm compare registers are checked against that count, and a status register records each match until software acknowledges it. A separate oscillator and prescaler produce the tick. The block only stores the frequency-correction word and hands it to that prescaler on a dedicated output.

Each alarm has its own interrupt configuration. One bit routes the latched alarm event to the alarm's interrupt line. A second bit adds a periodic one-cycle pulse to that line, and a third bit chooses the pulse rate: either the one-second tick itself, or a faster internal rate of one pulse every `FAST_DIV` clock cycles. A configuration/test word powers up with a nonzero low byte, which tells software that the clock has not been set up yet.

Access is through a simple 32-bit port with a 3-bit word address. Writes take effect at the clock edge where `wr_en` is high. Read data is combinational from the address.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, every register reads zero except the configuration/test word, which reads 0x000000FF. `irq_o` is low and `corr_o` is zero.
- R2: The word address selects these registers: 0 status, 1 alarm-1 config, 2 alarm-2 config, 3 seconds count, 4 alarm-1 value, 5 alarm-2 value, 6 correction, 7 configuration/test. `rdata_o` shows the addressed register in the same cycle.
- R3: In a cycle with `tick_i` high and no write to the seconds count, the count increases by one at the clock edge, wrapping from 0xFFFFFFFF to 0.
- R4: A write to the seconds count loads `wdata_i` at the edge. It takes priority over a tick in the same cycle.
- R5: A status bit sets (bit 0 for alarm 1, bit 1 for alarm 2) at the edge where a tick advances the count to equal that alarm's value. Loading the count with a write does not set it.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A set bit stays set until it is cleared this way.
- R7: When an alarm event and a clear of the same status bit fall in one cycle, the bit ends up set.
- R8: Bit 0 of an alarm config enables `irq_o[k]` whenever that alarm's status bit is set. With all config bits zero, the line stays low.
- R9: Bit 1 of an alarm config adds a periodic pulse to `irq_o[k]`. Bit 2 set makes the pulse follow `tick_i`. Bit 2 clear makes it a one-cycle pulse every `FAST_DIV` clocks.
- R10: The config registers keep bits [2:0] only, and read zero above them.
- R11: The correction register keeps bits [15:0] (bit 15 selects coarse mode, bit 13 selects nominal timing) and drives them on `corr_o`. It reads zero above bit 15.
- R12: The configuration/test word is fully writable. Writing zero clears the uninitialized marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 2 | Interrupt per alarm |
| corr_o | output | 16 | Stored correction word for the prescaler |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a tick and a software load of the seconds count. The bench drives both together and expects the count to hold the written value. The second pair is an alarm match and a write-1 acknowledge of that same status bit. The bench sets the count one below alarm 2 and then issues a tick together with a status write of 0b11 in a single cycle. It expects status to read 2: the new event survives, and the already-clear bit 0 stays clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [2:0] {
      RA_STAT = 3'd0,
      RA_CFG1 = 3'd1,
      RA_CFG2 = 3'd2,
      RA_TIME = 3'd3,
      RA_AL1  = 3'd4,
      RA_AL2  = 3'd5,
      RA_CORR = 3'd6,
      RA_CONF = 3'd7
   } reg_addr_e;

   localparam int CFG_W      = 3;
   localparam int CFG_ALM_EN = 0;
   localparam int CFG_PER_EN = 1;
   localparam int CFG_PER_1S = 2;
   localparam logic [7:0] UNINIT_MARK = 8'hFF;
endpackage

// File: rtl/rtc_pulse_gen.sv
module rtc_pulse_gen #(
   parameter int FAST_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse_o
);
   localparam int CW = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
   localparam bit POW2 = (FAST_DIV == (1 << CW));

   initial assert (FAST_DIV >= 2) else $error("FAST_DIV must be at least 2");

   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         assign pulse_o = &cnt_q;
      end else begin : g_term
         localparam logic [CW-1:0] LAST = CW'(FAST_DIV - 1);
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         assign pulse_o = (cnt_q == LAST);
      end
   endgenerate

   // R9: the fast pulse is never wider than one cycle
   a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
   import rtc_pkg::*;
#(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_val_i,
   input  logic          wr_cfg_i,
   input  logic [TW-1:0] wdata_i,
   input  logic          ack_i,
   input  logic          advance_i,
   input  logic [TW-1:0] next_time_i,
   input  logic          sec_pulse_i,
   input  logic          fast_pulse_i,
   output logic [TW-1:0] value_o,
   output logic [CFG_W-1:0] cfg_o,
   output logic          flag_o,
   output logic          irq_o
);
   logic evt;
   logic per_pulse;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         value_o <= '0;
         cfg_o   <= '0;
      end else begin
         if (wr_val_i) value_o <= wdata_i;
         if (wr_cfg_i) cfg_o   <= wdata_i[CFG_W-1:0];
      end

   assign evt = advance_i && (next_time_i == value_o);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       flag_o <= 1'b0;
      else if (evt)     flag_o <= 1'b1;
      else if (ack_i)   flag_o <= 1'b0;

   assign per_pulse = cfg_o[CFG_PER_1S] ? sec_pulse_i : fast_pulse_i;
   assign irq_o = (flag_o && cfg_o[CFG_ALM_EN]) || (cfg_o[CFG_PER_EN] && per_pulse);

   // R6: an acknowledge without a new event clears the flag
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i && !evt |=> !flag_o);
   // R7: an event always leaves the flag set, acknowledged or not
   a_r7_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_o);
   // R6: a set flag holds until acknowledged
   a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o && !ack_i |=> flag_o);
   // R8: an unconfigured alarm never raises its line
   a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_o == '0) |-> !irq_o);
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
   import rtc_pkg::*;
#(
   parameter int TW       = 32,
   parameter int CORR_W   = 16,
   parameter int N_ALARM  = 2,
   parameter int FAST_DIV = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          wr_en_i,
   input  logic [2:0]    addr_i,
   input  logic [31:0]   wdata_i,
   output logic [31:0]   rdata_o,
   output logic [1:0]    irq_o,
   output logic [15:0]   corr_o
);
   initial assert (TW == 32 && CORR_W == 16 && N_ALARM == 2)
      else $error("register map is fixed at 32-bit words, 16-bit correction, two alarms");

   reg_addr_e        ra;
   logic [TW-1:0]    time_q;
   logic [TW-1:0]    next_time;
   logic             time_wr;
   logic             advance;
   logic             fast_pulse;
   logic [CORR_W-1:0] corr_q;
   logic [31:0]      conf_q;
   logic [TW-1:0]    al_val [N_ALARM];
   logic [CFG_W-1:0] al_cfg [N_ALARM];
   logic [N_ALARM-1:0] flags;

   assign ra        = reg_addr_e'(addr_i);
   assign time_wr   = wr_en_i && (ra == RA_TIME);
   assign advance   = tick_i && !time_wr;
   assign next_time = time_q + TW'(1);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       time_q <= '0;
      else if (time_wr) time_q <= wdata_i;
      else if (advance) time_q <= next_time;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         corr_q <= '0;
         conf_q <= {24'd0, UNINIT_MARK};
      end else if (wr_en_i) begin
         if (ra == RA_CORR) corr_q <= wdata_i[CORR_W-1:0];
         if (ra == RA_CONF) conf_q <= wdata_i;
      end

   rtc_pulse_gen #(.FAST_DIV(FAST_DIV)) u_fast (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_o (fast_pulse)
   );

   generate
      for (genvar k = 0; k < N_ALARM; k++) begin : g_alarm
         localparam reg_addr_e VAL_A = reg_addr_e'(RA_AL1 + k);
         localparam reg_addr_e CFG_A = reg_addr_e'(RA_CFG1 + k);
         rtc_alarm_unit #(.TW(TW)) u_alm (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_val_i     (wr_en_i && (ra == VAL_A)),
            .wr_cfg_i     (wr_en_i && (ra == CFG_A)),
            .wdata_i      (wdata_i),
            .ack_i        (wr_en_i && (ra == RA_STAT) && wdata_i[k]),
            .advance_i    (advance),
            .next_time_i  (next_time),
            .sec_pulse_i  (tick_i),
            .fast_pulse_i (fast_pulse),
            .value_o      (al_val[k]),
            .cfg_o        (al_cfg[k]),
            .flag_o       (flags[k]),
            .irq_o        (irq_o[k])
         );
      end
   endgenerate

   always_comb begin
      unique case (ra)
         RA_STAT: rdata_o = {30'd0, flags};
         RA_CFG1: rdata_o = {29'd0, al_cfg[0]};
         RA_CFG2: rdata_o = {29'd0, al_cfg[1]};
         RA_TIME: rdata_o = time_q;
         RA_AL1:  rdata_o = al_val[0];
         RA_AL2:  rdata_o = al_val[1];
         RA_CORR: rdata_o = {16'd0, corr_q};
         RA_CONF: rdata_o = conf_q;
         default: rdata_o = '0;
      endcase
   end

   assign corr_o = corr_q;

   // R3: a tick without a load advances the count by one
   a_r3_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !(wr_en_i && addr_i == 3'd3) |=> time_q == $past(time_q) + 32'd1);
   // R4: a load of the count wins over a tick
   a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && addr_i == 3'd3 |=> time_q == $past(wdata_i));
   // R3: without tick or load the count holds
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !(wr_en_i && addr_i == 3'd3) |=> $stable(time_q));
endmodule

// File: tb/sim_rtc_sec_core.sv
`timescale 1ns/1ps
module sim_rtc_sec_core;
   localparam int FDIV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  addr_i = 3'd0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic [1:0]  irq_o;
   logic [15:0] corr_o;

   int total = 0;
   int bad = 0;
   bit mon_req = 1'b0;
   bit finished = 1'b0;

   int          kind_q [$];
   logic [31:0] exp_q  [$];
   string       tag_q  [$];

   always #2.5 clk = ~clk;

   rtc_sec_core #(.FAST_DIV(FDIV)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .irq_o(irq_o), .corr_o(corr_o)
   );

   task automatic judge(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // monitor: compares queued expectations against the outputs
   always @(negedge clk) begin
      if (mon_req && kind_q.size() > 0) begin
         int k;
         logic [31:0] e;
         string t;
         k = kind_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         case (k)
            0: judge(t, rdata_o, e);
            1: judge(t, {30'd0, irq_o}, e);
            default: judge(t, {16'd0, corr_o}, e);
         endcase
      end
   end

   // one cycle: drive inputs after the edge, optionally queue a check (kind<0: none)
   task automatic op(input bit we, input logic [2:0] a, input logic [31:0] wd,
                     input bit tk, input int kind, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      wr_en_i = we; addr_i = a; wdata_i = wd; tick_i = tk;
      mon_req = (kind >= 0);
      if (kind >= 0) begin
         kind_q.push_back(kind); exp_q.push_back(exp); tag_q.push_back(tag);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] wd);
      op(1'b1, a, wd, 1'b0, -1, '0, "");
   endtask
   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      op(1'b0, a, '0, 1'b0, 0, exp, tag);
   endtask
   task automatic tk();
      op(1'b0, 3'd0, '0, 1'b1, -1, '0, "");
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 7; i++) rd(3'(i), 32'd0, "R1 reg zero");
      rd(3'd7, 32'h000000FF, "R1 init marker");
      op(1'b0, 3'd0, '0, 1'b0, 1, 32'd0, "R1 irq low");
      op(1'b0, 3'd0, '0, 1'b0, 2, 32'd0, "R1 corr low");
      // R2 / R10 / R11 / R12
      wr(3'd4, 32'h12345678);
      rd(3'd4, 32'h12345678, "R2 alarm1 value");
      wr(3'd1, 32'hFFFFFFFF);
      rd(3'd1, 32'h7, "R10 cfg1 width");
      wr(3'd1, 32'h0);
      wr(3'd6, 32'hFFFFA000);
      rd(3'd6, 32'h0000A000, "R11 corr readback");
      op(1'b0, 3'd0, '0, 1'b0, 2, 32'h0000A000, "R11 corr_o");
      wr(3'd7, 32'h0);
      rd(3'd7, 32'h0, "R12 marker cleared");
      // R3 increment and wrap (alarm2 value 0 matches on wrap)
      wr(3'd3, 32'hFFFFFFFE);
      tk();
      rd(3'd3, 32'hFFFFFFFF, "R3 increment");
      tk();
      rd(3'd3, 32'h0, "R3 wrap");
      rd(3'd0, 32'h2, "R5 alarm2 on wrap");
      wr(3'd0, 32'h2);
      rd(3'd0, 32'h0, "R6 ack clears");
      // R4 load beats tick
      op(1'b1, 3'd3, 32'd100, 1'b1, -1, '0, "");
      rd(3'd3, 32'd100, "R4 load over tick");
      // R5 tick match
      wr(3'd4, 32'd102);
      tk();
      rd(3'd0, 32'h0, "R5 no early event");
      tk();
      rd(3'd0, 32'h1, "R5 alarm1 event");
      wr(3'd0, 32'h0);
      rd(3'd0, 32'h1, "R6 zero write keeps");
      wr(3'd1, 32'h1);
      op(1'b0, 3'd0, '0, 1'b0, 1, 32'h1, "R8 irq enabled");
      wr(3'd0, 32'h1);
      rd(3'd0, 32'h0, "R6 ack bit0");
      op(1'b0, 3'd0, '0, 1'b0, 1, 32'h0, "R8 irq drops");
      wr(3'd3, 32'd102);
      rd(3'd0, 32'h0, "R5 load no event");
      // R7 event and ack together
      wr(3'd3, 32'd200);
      wr(3'd5, 32'd201);
      op(1'b1, 3'd0, 32'h3, 1'b1, -1, '0, "");
      rd(3'd0, 32'h2, "R7 event wins");
      op(1'b0, 3'd0, '0, 1'b0, 1, 32'h0, "R8 cfg2 off masks");
      // R9 periodic at tick rate
      wr(3'd1, 32'h6);
      op(1'b0, 3'd0, '0, 1'b1, 1, 32'h1, "R9 1s pulse on tick");
      op(1'b0, 3'd0, '0, 1'b0, 1, 32'h0, "R9 1s pulse idle");
      // R9 fast rate
      wr(3'd1, 32'h2);
      op(1'b0, 3'd0, '0, 1'b0, -1, '0, "");
      begin
         int cnt = 0;
         for (int c = 0; c < 4 * FDIV; c++) begin
            @(negedge clk);
            if (irq_o[0]) cnt++;
         end
         judge("R9 fast pulse count", 32'(cnt), 32'd4);
      end
      @(posedge clk); #1 mon_req = 1'b0;
      @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule